// File: doc/BRIEF.md
# Performance monitor counter unit

This unit holds six event counters and one control register for on-chip performance measurement. Four of them are general counters. Each counts pulses on its own event input, can be loaded by software and is stopped by a global freeze bit or by a freeze bit for the current privilege mode. When its most significant bit becomes 1 it is treated as overflowed and can raise an alert. The other two are limited counters. One counts completed instructions and the other counts cycle strobes, and both count only while the run-state input is high. Both are read-only, and neither the freeze bits nor the alert logic affect them.

Software measures a span by reading a counter twice and subtracting modulo 2^CNT_W. To sample every P events, it loads a general counter with 2^(CNT_W-1) - P and enables the alert. The alert output is a level. It stays high until software clears the alert flag in the control register. The control register can also ask the unit to set the global freeze bit whenever an alert is raised, so that the general counters stop close to the overflow point.

Top module: `pmc_unit`

## Requirements
- R1: After reset every counter reads 0, the control register reads 0x01 (global freeze set, all other bits 0) and `alert` is low.
- R2: Each general counter (address i for counter i, i = 1..4) increments by one on every clock edge where its `ev_pulse` bit is high and it is not frozen. It wraps from all ones to 0.
- R3: While control bit 0 (global freeze) is 1, the general counters do not count.
- R4: Control bit 1 freezes the general counters while `priv_mode` = 0 (user). Bit 2 freezes them while `priv_mode` = 1 (supervisor). Bit 3 freezes them while `priv_mode` is 2 or 3 (hypervisor). A freeze bit for any other mode has no effect.
- R5: A write to address 1..4 loads that general counter on the next edge. On that edge the write takes priority over an event pulse.
- R6: The counter at address 5 increments on each edge where `instr_done` and `run_state` are both high. The counter at address 6 increments on each edge where `cyc_tick` and `run_state` are both high. Control bits 0..3 have no effect on either.
- R7: Writes to addresses 5, 6 and 7 change no state.
- R8: When control bit 4 (alert enable) is 1 and any general counter has its MSB set, control bit 6 (alert flag) is set on the next edge. `alert` follows bit 6. With bit 4 at 0, no overflow sets the flag. The limited counters never set it.
- R9: When control bits 4 and 5 (freeze on alert) are both 1, the overflow condition sets the global freeze bit on the same edge that sets the alert flag.
- R10: The alert flag stays set until software writes control bit 6 as 0. The write clears the flag only if the overflow condition is absent on that edge.
- R11: `rdata` is registered. It shows, one cycle after `addr` is presented, the addressed register as it was at that edge. Address 0 returns the control register in bits 6:0 with zeros above, and address 7 returns 0.
- R12: A general counter loaded with 2^(CNT_W-1) - P sets its MSB after exactly P counted events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | N_GEN | One event pulse per general counter |
| instr_done | input | 1 | Instruction-complete strobe for counter 5 |
| cyc_tick | input | 1 | Cycle strobe for counter 6 |
| run_state | input | 1 | Run bit that gates the limited counters |
| priv_mode | input | 2 | 0 user, 1 supervisor, 2 or 3 hypervisor |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address for both read and write |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| alert | output | 1 | Level-sensitive overflow alert |

## Verification
The bench builds one unit with the default 32-bit counters and four general counters. On that unit it exercises the freeze matrix, the period arming at the 0x7FFFFFFF to 0x80000000 crossing, and the wrap from all ones. A second unit with CNT_W = 8 lets the limited counters reach their MSB within 130 cycles. That makes it possible to observe, at the ports, that they never raise the alert. A 32-bit limited counter would need 2^31 strobes to show the same thing.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  // control register bit positions
  localparam int CB_GFRZ      = 0;
  localparam int CB_FRZ_USR   = 1;
  localparam int CB_FRZ_SUP   = 2;
  localparam int CB_FRZ_HYP   = 3;
  localparam int CB_ALERT_EN  = 4;
  localparam int CB_FRZ_ALERT = 5;
  localparam int CB_ALERT_FLG = 6;
  localparam int CTRL_W       = 7;

  localparam logic [1:0] MODE_USER = 2'd0;
  localparam logic [1:0] MODE_SUP  = 2'd1;

  typedef logic [CTRL_W-1:0] ctrl_t;
endpackage

// File: rtl/pmc_gen_counter.sv
module pmc_gen_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (wr)     cnt <= wdata;
    else if (cnt_en) cnt <= cnt + 1'b1;
  end

  assign ovf = cnt[CNT_W-1];

  assert_frozen_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !wr) |=> $stable(cnt));
  assert_write_load_R5: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cnt == $past(wdata)));
endmodule

// File: rtl/pmc_run_counter.sv
module pmc_run_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             run,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (strobe && run) cnt <= cnt + 1'b1;
  end

  assert_run_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr,
  input  ctrl_t wdata,
  input  logic  any_ovf,
  output ctrl_t ctrl
);
  ctrl_t nxt;
  logic  fire;

  assign fire = ctrl[CB_ALERT_EN] && any_ovf;

  always_comb begin
    nxt = wr ? wdata : ctrl;
    if (fire) begin
      nxt[CB_ALERT_FLG] = 1'b1;
      if (ctrl[CB_FRZ_ALERT]) nxt[CB_GFRZ] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl           <= '0;
      ctrl[CB_GFRZ]  <= 1'b1;
    end else begin
      ctrl <= nxt;
    end
  end

  assert_alert_set_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl[CB_ALERT_EN] && any_ovf) |=> ctrl[CB_ALERT_FLG]);
  assert_freeze_on_alert_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl[CB_ALERT_EN] && ctrl[CB_FRZ_ALERT] && any_ovf) |=> ctrl[CB_GFRZ]);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl[CB_ALERT_FLG] && !wr) |=> ctrl[CB_ALERT_FLG]);
endmodule

// File: rtl/pmc_unit.sv
module pmc_unit
  import pmc_pkg::*;
#(
  parameter int  N_GEN = 4,
  parameter int  CNT_W = 32,
  localparam int AW    = $clog2(N_GEN + 3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_GEN-1:0] ev_pulse,
  input  logic             instr_done,
  input  logic             cyc_tick,
  input  logic             run_state,
  input  logic [1:0]       priv_mode,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             alert
);
  localparam logic [AW-1:0] A_CTRL  = '0;
  localparam logic [AW-1:0] A_INSTR = AW'(N_GEN + 1);
  localparam logic [AW-1:0] A_CYC   = AW'(N_GEN + 2);

  ctrl_t            ctrl;
  logic             mode_frz;
  logic             gen_stop;
  logic [N_GEN-1:0] gen_ovf;
  logic [CNT_W-1:0] gen_cnt [N_GEN];
  logic [CNT_W-1:0] instr_cnt, cyc_cnt;
  logic [CNT_W-1:0] rd_next;

  always_comb begin
    if (priv_mode == MODE_USER)     mode_frz = ctrl[CB_FRZ_USR];
    else if (priv_mode == MODE_SUP) mode_frz = ctrl[CB_FRZ_SUP];
    else                            mode_frz = ctrl[CB_FRZ_HYP];
  end
  assign gen_stop = ctrl[CB_GFRZ] || mode_frz;

  pmc_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_en && (addr == A_CTRL)),
    .wdata   (wdata[CTRL_W-1:0]),
    .any_ovf (|gen_ovf),
    .ctrl    (ctrl)
  );

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    pmc_gen_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .cnt_en (ev_pulse[g] && !gen_stop),
      .wr     (wr_en && (addr == AW'(g + 1))),
      .wdata  (wdata),
      .cnt    (gen_cnt[g]),
      .ovf    (gen_ovf[g])
    );
  end

  pmc_run_counter #(.CNT_W(CNT_W)) u_instr (
    .clk (clk), .rst (rst), .strobe (instr_done), .run (run_state), .cnt (instr_cnt)
  );
  pmc_run_counter #(.CNT_W(CNT_W)) u_cyc (
    .clk (clk), .rst (rst), .strobe (cyc_tick), .run (run_state), .cnt (cyc_cnt)
  );

  always_comb begin
    rd_next = '0;
    if (addr == A_CTRL) rd_next[CTRL_W-1:0] = ctrl;
    if (addr == A_INSTR) rd_next = instr_cnt;
    if (addr == A_CYC)   rd_next = cyc_cnt;
    for (int i = 0; i < N_GEN; i++)
      if (addr == AW'(i + 1)) rd_next = gen_cnt[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  assign alert = ctrl[CB_ALERT_FLG];

  assert_alert_source_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(alert) && !$past(wr_en && (addr == A_CTRL))) |-> $past(|gen_ovf));
  assert_limited_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == A_INSTR) && !run_state) |=> $stable(instr_cnt));
endmodule

// File: tb/pmc_unit_bench.sv
module pmc_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ev_pulse = '0;
  logic        instr_done = 1'b0, cyc_tick = 1'b0, run_state = 1'b0;
  logic [1:0]  priv_mode = 2'd0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        alert;

  // narrow unit: limited counters reach their MSB quickly
  logic        n_instr = 1'b0, n_tick = 1'b0, n_run = 1'b0, n_wr = 1'b0;
  logic [2:0]  n_addr = '0;
  logic [7:0]  n_wdata = '0;
  logic [7:0]  n_rdata;
  logic        n_alert;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pmc_unit u_pmc_unit (
    .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .instr_done(instr_done),
    .cyc_tick(cyc_tick), .run_state(run_state), .priv_mode(priv_mode),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .alert(alert)
  );

  pmc_unit #(.N_GEN(4), .CNT_W(8)) u_pmc_narrow (
    .clk(clk), .rst(rst), .ev_pulse(4'b0), .instr_done(n_instr),
    .cyc_tick(n_tick), .run_state(n_run), .priv_mode(2'd0),
    .wr_en(n_wr), .addr(n_addr), .wdata(n_wdata), .rdata(n_rdata), .alert(n_alert)
  );

  // {ctrl, priv_mode, event mask, counts?}
  localparam logic [13:0] VEC [10] = '{
    {7'h00, 2'd0, 4'hF, 1'b1},
    {7'h01, 2'd0, 4'hF, 1'b0},
    {7'h02, 2'd0, 4'h5, 1'b0},
    {7'h02, 2'd1, 4'h5, 1'b1},
    {7'h04, 2'd1, 4'hA, 1'b0},
    {7'h04, 2'd2, 4'hA, 1'b1},
    {7'h08, 2'd2, 4'h3, 1'b0},
    {7'h08, 2'd3, 4'h3, 1'b0},
    {7'h08, 2'd0, 4'hC, 1'b1},
    {7'h06, 2'd2, 4'h9, 1'b1}
  };

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic pulse(input logic [3:0] m, input int n);
    @(negedge clk); ev_pulse = m;
    repeat (n) @(negedge clk);
    ev_pulse = '0;
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk({31'b0, alert}, 32'h0, "R1 alert");
    rd(3'd0, v); chk(v, 32'h01, "R1 ctrl");
    for (int a = 1; a <= 6; a++) begin
      rd(3'(a), v); chk(v, 32'h0, "R1 counter");
    end

    // R2 R3 R4 freeze matrix table
    foreach (VEC[r]) begin
      for (int i = 1; i <= 4; i++) wr(3'(i), 32'h0);
      priv_mode = VEC[r][6:5];
      wr(3'd0, {25'b0, VEC[r][13:7]});
      pulse(VEC[r][4:1], 3);
      for (int i = 0; i < 4; i++) begin
        rd(3'(i + 1), v);
        chk(v, (VEC[r][1 + i] && VEC[r][0]) ? 32'd3 : 32'd0, "R2/R3/R4 freeze table");
      end
    end

    // R5 write beats an event on the same edge
    priv_mode = 2'd0;
    wr(3'd0, 32'h0);
    @(negedge clk); ev_pulse = 4'b0001; wr_en = 1'b1; addr = 3'd1; wdata = 32'h10;
    @(negedge clk); wr_en = 1'b0; ev_pulse = '0;
    rd(3'd1, v); chk(v, 32'h10, "R5 write priority");
    pulse(4'b0001, 1);
    rd(3'd1, v); chk(v, 32'h11, "R5 count after load");

    // R2 wrap
    wr(3'd2, 32'hFFFF_FFFF);
    pulse(4'b0010, 1);
    rd(3'd2, v); chk(v, 32'h0, "R2 wrap");

    // R6 limited counters gated by run only
    wr(3'd0, 32'h0F);
    @(negedge clk); run_state = 1'b1; instr_done = 1'b1; cyc_tick = 1'b1;
    repeat (5) @(negedge clk);
    instr_done = 1'b0;
    repeat (2) @(negedge clk);
    cyc_tick = 1'b0; run_state = 1'b0;
    @(negedge clk); instr_done = 1'b1; cyc_tick = 1'b1;
    repeat (4) @(negedge clk);
    instr_done = 1'b0; cyc_tick = 1'b0;
    rd(3'd5, v); chk(v, 32'd5, "R6 instr counter");
    rd(3'd6, v); chk(v, 32'd7, "R6 cycle counter");

    // R7 writes ignored, R11 unused address
    wr(3'd5, 32'h1234);
    wr(3'd6, 32'hABCD);
    wr(3'd7, 32'h55);
    rd(3'd5, v); chk(v, 32'd5, "R7 instr unchanged");
    rd(3'd6, v); chk(v, 32'd7, "R7 cycle unchanged");
    rd(3'd7, v); chk(v, 32'h0, "R11 unused address");

    // R12 R8 R9 period arming, alert, freeze on alert
    wr(3'd0, 32'h30);
    wr(3'd3, 32'h8000_0000 - 32'd4);
    pulse(4'b0100, 3);
    rd(3'd3, v); chk(v, 32'h7FFF_FFFF, "R12 before crossing");
    chk({31'b0, alert}, 32'h0, "R8 no alert before crossing");
    @(negedge clk); ev_pulse = 4'b0100;
    @(negedge clk);
    chk({31'b0, alert}, 32'h0, "R8 alert one edge after MSB");
    @(negedge clk);
    chk({31'b0, alert}, 32'h1, "R8 alert raised");
    @(negedge clk); ev_pulse = '0;
    rd(3'd3, v); chk(v, 32'h8000_0001, "R9 frozen after alert edge");
    rd(3'd0, v); chk(v, 32'h71, "R9 ctrl freeze and flag");

    // R10 sticky alert
    repeat (4) @(negedge clk);
    chk({31'b0, alert}, 32'h1, "R10 alert held");
    wr(3'd0, 32'h30);
    chk({31'b0, alert}, 32'h1, "R10 clear refused while overflowed");
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h30);
    chk({31'b0, alert}, 32'h0, "R10 clear accepted");

    // R8 alert disabled
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h8000_0005);
    repeat (3) @(negedge clk);
    chk({31'b0, alert}, 32'h0, "R8 no alert when disabled");
    rd(3'd0, v); chk(v, 32'h0, "R8 ctrl flag clear");

    // R8 limited counters never alert (narrow unit)
    @(negedge clk); n_wr = 1'b1; n_addr = 3'd0; n_wdata = 8'h30;
    @(negedge clk); n_wr = 1'b0; n_run = 1'b1; n_tick = 1'b1; n_instr = 1'b1;
    repeat (130) @(negedge clk);
    n_run = 1'b0; n_tick = 1'b0; n_instr = 1'b0; n_addr = 3'd6;
    @(negedge clk);
    chk({24'b0, n_rdata}, 32'h82, "R6 narrow cycle counter MSB");
    n_addr = 3'd5;
    @(negedge clk);
    chk({24'b0, n_rdata}, 32'h82, "R6 narrow instr counter MSB");
    chk({31'b0, n_alert}, 32'h0, "R8 limited counters raise no alert");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule